// File: doc/BRIEF.md
# Non-Volatile Register Bank Save/Recall Controller

This block models a bank of register bits. Each bit has a fast live flip-flop and a non-volatile shadow copy. In normal operation the live register takes the data input on every clock, at full speed, and the shadow copy plays no part. A controller runs two operations on request: a save, which copies the live value into the shadow copy, and a recall, which overwrites the live register with the shadow contents.

A save models a thermally assisted write. The controller snapshots the live value when it accepts the request. It then spends a programmable number of cycles heating, then a programmable number with the write field applied, then a programmable number cooling. Only then does the save report done. The shadow bit is held as a complementary pair, and the pair is committed when the write-field phase ends. A recall models an equalise pulse. For one cycle the live register is forced to zero, then it settles to the shadow value, and the done flag pulses with it. A power-good input models the supply being switched off: while it is low the live bits read zero and the controller is idle, but the shadow pairs keep their contents.

Top module: `nvreg_bank`

## Requirements
- R1: After reset, `q_out` is 0, `busy` is 0 and `done` is 0.
- R2: While idle and powered, `q_out` equals the `d_in` value present at the previous rising clock edge.
- R3: A save accepted at an edge holds `busy` high for exactly HEAT_CYC+WRITE_CYC+COOL_CYC cycles. `done` then goes high for exactly one cycle, with `busy` low.
- R4: While a save is in progress, `q_out` keeps following `d_in` with one cycle of latency, exactly as in R2.
- R5: A save stores the `q_out` value that was present at the edge where the save was accepted. A later recall returns that value, even if the live data has changed since.
- R6: A recall accepted at an edge behaves as follows. `busy` is high for 2 cycles. In the second of these cycles `q_out` reads 0. In the cycle after that, `q_out` shows the stored value, `done` is high for one cycle and `busy` is low. On the next edge the live register resumes following `d_in`.
- R7: A recall request that arrives during a save, or together with a save request in the same cycle, is held. The recall is accepted at the edge after the save's done cycle.
- R8: A save request that arrives during a recall is dropped. After the recall's done cycle, `busy` stays low and no further `done` appears.
- R9: While `pwr_ok` is low, `q_out` reads 0 from the next edge on and both requests are ignored (`busy` stays 0). The shadow contents survive, so a recall after power returns gives back the value saved before the loss.
- R10: If `pwr_ok` falls during the heating phase, the save is abandoned. No `done` appears and the shadow keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset, including the shadow |
| pwr_ok | input | 1 | Supply good; low models the domain switched off |
| d_in | input | WIDTH | Data captured by the live register each cycle |
| save_req | input | 1 | Request to copy the live value into the shadow |
| load_req | input | 1 | Request to overwrite the live value from the shadow |
| q_out | output | WIDTH | Live register value |
| busy | output | 1 | High while a save or recall is in progress |
| done | output | 1 | One-cycle pulse when an operation completes |

## Verification
A phase counter that is off by one moves the falling edge of `busy` and the `done` pulse by one cycle. The bench times every save against the sum of the phase lengths, so this error appears on the first operation. If the snapshot is taken at the wrong time, or the complementary pair is committed incorrectly, the error stays hidden until the next recall. The value recalled into `q_out` then differs from the value saved, and the bench detects this by sweeping every 8-bit value through a save followed by a recall. If a deferred recall is lost, or a dropped save is wrongly replayed, the `busy` and `done` sequence is wrong within three cycles of the first operation completing.

// File: rtl/nvr_pkg.sv
package nvr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_HEAT   = 3'd1,
    ST_WRITE  = 3'd2,
    ST_COOL   = 3'd3,
    ST_AZ     = 3'd4,
    ST_SETTLE = 3'd5
  } nvr_state_t;

  // Total busy cycles of one save operation.
  function automatic int save_span(input int heat, input int wr, input int cool);
    return heat + wr + cool;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Differential read of a shadow pair: bit is 1 when element A holds 1 and B holds 0.
  function automatic logic pair_read(input logic a, input logic b);
    return a & ~b;
  endfunction

endpackage

// File: rtl/nvr_seq.sv
module nvr_seq
  import nvr_pkg::*;
#(
  parameter int HEAT_CYC  = 2,
  parameter int WRITE_CYC = 1,
  parameter int COOL_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic save_req,
  input  logic load_req,
  output logic busy,
  output logic done,
  output logic ev_accept,
  output logic ev_commit,
  output logic ev_az,
  output logic ev_settle
);
  localparam int MAXP = max3(HEAT_CYC, WRITE_CYC, COOL_CYC);
  localparam int CW   = (MAXP > 1) ? $clog2(MAXP) : 1;
  localparam logic [CW-1:0] HEAT_LAST  = CW'(HEAT_CYC - 1);
  localparam logic [CW-1:0] WRITE_LAST = CW'(WRITE_CYC - 1);
  localparam logic [CW-1:0] COOL_LAST  = CW'(COOL_CYC - 1);

  nvr_state_t    state;
  logic [CW-1:0] cnt;
  logic          pend;
  logic          in_save;

  assign in_save   = (state == ST_HEAT) || (state == ST_WRITE) || (state == ST_COOL);
  assign busy      = (state != ST_IDLE);
  assign ev_accept = (state == ST_IDLE) && save_req && pwr_ok;
  assign ev_commit = (state == ST_WRITE) && (cnt == WRITE_LAST) && pwr_ok;
  assign ev_az     = (state == ST_AZ);
  assign ev_settle = (state == ST_SETTLE);

  always_ff @(posedge clk) begin
    if (!rst_n || !pwr_ok) begin
      state <= ST_IDLE;
      cnt   <= '0;
      pend  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (in_save && load_req) pend <= 1'b1;
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (save_req) begin
            state <= ST_HEAT;
            if (load_req) pend <= 1'b1;
          end else if (load_req || pend) begin
            state <= ST_AZ;
            pend  <= 1'b0;
          end
        end
        ST_HEAT: begin
          if (cnt == HEAT_LAST) begin
            state <= ST_WRITE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_WRITE: begin
          if (cnt == WRITE_LAST) begin
            state <= ST_COOL;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_COOL: begin
          if (cnt == COOL_LAST) begin
            state <= ST_IDLE;
            cnt   <= '0;
            done  <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        ST_AZ:     state <= ST_SETTLE;
        ST_SETTLE: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default:   state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nvr_shadow.sv
module nvr_shadow
  import nvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_accept,
  input  logic             ev_commit,
  input  logic [WIDTH-1:0] live_q,
  output logic [WIDTH-1:0] pair_a,
  output logic [WIDTH-1:0] pair_b,
  output logic [WIDTH-1:0] stored
);
  logic [WIDTH-1:0] snap;

  always_ff @(posedge clk) begin
    if (!rst_n) snap <= '0;
    else if (ev_accept) snap <= live_q;
  end

  // Supply-independent: only reset or a commit changes the pairs.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pair_a <= '0;
      pair_b <= '1;
    end else if (ev_commit) begin
      pair_a <= snap;
      pair_b <= ~snap;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_read
    assign stored[i] = pair_read(pair_a[i], pair_b[i]);
  end
endmodule

// File: rtl/nvr_live.sv
module nvr_live #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_ok,
  input  logic             ev_az,
  input  logic             ev_settle,
  input  logic [WIDTH-1:0] d_in,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n || !pwr_ok) q <= '0;
    else if (ev_az)        q <= '0;
    else if (ev_settle)    q <= stored;
    else                   q <= d_in;
  end
endmodule

// File: rtl/nvreg_bank.sv
module nvreg_bank #(
  parameter int WIDTH     = 8,
  parameter int HEAT_CYC  = 2,
  parameter int WRITE_CYC = 1,
  parameter int COOL_CYC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_ok,
  input  logic [WIDTH-1:0] d_in,
  input  logic             save_req,
  input  logic             load_req,
  output logic [WIDTH-1:0] q_out,
  output logic             busy,
  output logic             done
);
  logic             ev_accept, ev_commit, ev_az, ev_settle;
  logic [WIDTH-1:0] pair_a, pair_b, stored;

  nvr_seq #(.HEAT_CYC(HEAT_CYC), .WRITE_CYC(WRITE_CYC), .COOL_CYC(COOL_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok),
    .save_req(save_req), .load_req(load_req),
    .busy(busy), .done(done),
    .ev_accept(ev_accept), .ev_commit(ev_commit),
    .ev_az(ev_az), .ev_settle(ev_settle)
  );

  nvr_shadow #(.WIDTH(WIDTH)) u_shadow (
    .clk(clk), .rst_n(rst_n),
    .ev_accept(ev_accept), .ev_commit(ev_commit),
    .live_q(q_out), .pair_a(pair_a), .pair_b(pair_b), .stored(stored)
  );

  nvr_live #(.WIDTH(WIDTH)) u_live (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok),
    .ev_az(ev_az), .ev_settle(ev_settle),
    .d_in(d_in), .stored(stored), .q(q_out)
  );
endmodule

// File: rtl/nvreg_bank_chk.sv
module nvreg_bank_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_ok,
  input logic [WIDTH-1:0] d_in,
  input logic [WIDTH-1:0] q_out,
  input logic             busy,
  input logic             done,
  input logic             ev_commit,
  input logic             ev_az,
  input logic             ev_settle,
  input logic [WIDTH-1:0] pair_a,
  input logic [WIDTH-1:0] pair_b,
  input logic [WIDTH-1:0] stored
);
  a_r3_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_pair_complement: assert property (@(posedge clk) disable iff (!rst_n)
    pair_a == ~pair_b);

  a_r4_live_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && !ev_az && !ev_settle) |=> (q_out == $past(d_in)));

  a_r6_settle_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && ev_settle) |=> (q_out == $past(stored)));

  a_r6_equalise: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && ev_az) |=> (q_out == '0));

  a_r9_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (q_out == '0 && !busy));

  a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_commit |=> $stable(pair_a));
endmodule

bind nvreg_bank nvreg_bank_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .d_in(d_in), .q_out(q_out),
  .busy(busy), .done(done), .ev_commit(ev_commit), .ev_az(ev_az),
  .ev_settle(ev_settle), .pair_a(pair_a), .pair_b(pair_b), .stored(stored)
);

// File: tb/nvreg_bank_test.sv
module nvreg_bank_test;
  localparam int W = 8;
  localparam int H = 2, WR = 1, C = 2;
  localparam int SPAN = H + WR + C;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pwr_ok = 1'b1;
  logic [W-1:0] d_in = '0;
  logic         save_req = 1'b0;
  logic         load_req = 1'b0;
  logic [W-1:0] q_out;
  logic         busy, done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  nvreg_bank #(.WIDTH(W), .HEAT_CYC(H), .WRITE_CYC(WR), .COOL_CYC(C)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .d_in(d_in),
    .save_req(save_req), .load_req(load_req),
    .q_out(q_out), .busy(busy), .done(done)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Advance one edge; outputs are then examined at the following negedge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Save value v; optionally pulse a recall request in the second busy cycle.
  task automatic do_save(input logic [W-1:0] v, input bit with_load);
    d_in = v;
    step();
    check("R2 idle follow", q_out, v);
    save_req = 1'b1;
    step();
    save_req = 1'b0;
    for (int k = 0; k < SPAN; k++) begin
      check("R3 busy during save", busy, 1);
      check("R3 no early done", done, 0);
      if (k == 0) check("R4 live at accept", q_out, v);
      else check("R4 live follows", q_out, 8'(v + k));
      load_req = (with_load && k == 1);
      d_in = 8'(v + k + 1);
      step();
      load_req = 1'b0;
    end
    check("R3 done pulse", done, 1);
    check("R3 busy low at done", busy, 0);
  endtask

  // Recall starting from a cycle where the request is already accepted (state AZ).
  task automatic finish_load(input logic [W-1:0] exp, input bit poke_save);
    check("R6 busy az", busy, 1);
    save_req = poke_save;
    step();
    save_req = 1'b0;
    check("R6 equalised", q_out, 0);
    check("R6 busy settle", busy, 1);
    step();
    check("R5 recalled value", q_out, exp);
    check("R6 done", done, 1);
    check("R6 busy low", busy, 0);
    step();
    check("R6 resumes follow", q_out, d_in);
    check("R6 done single", done, 0);
  endtask

  task automatic do_load(input logic [W-1:0] exp, input bit poke_save);
    d_in = ~exp;
    load_req = 1'b1;
    step();
    load_req = 1'b0;
    finish_load(exp, poke_save);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    d_in = 8'h5A;
    step();
    step();
    check("R1 q reset", q_out, 0);
    check("R1 busy reset", busy, 0);
    check("R1 done reset", done, 0);
    rst_n = 1'b1;

    // Sweep every value through save then recall.
    for (int v = 0; v < 256; v++) begin
      do_save(8'(v), 1'b0);
      step();
      check("R3 done one cycle", done, 0);
      do_load(8'(v), 1'b0);
    end

    // Deferred recall (R7) and dropped save during recall (R8).
    for (int v = 3; v < 256; v += 37) begin
      do_save(8'(v), 1'b1);
      d_in = 8'hC3;
      step();
      check("R7 deferred recall starts", busy, 1);
      check("R7 done gone", done, 0);
      finish_load(8'(v), 1'b0);
      do_load(8'(v), 1'b1);
      for (int k = 0; k < 3; k++) begin
        step();
        check("R8 save dropped busy", busy, 0);
        check("R8 save dropped done", done, 0);
      end
    end

    // Simultaneous requests: save first, recall held (R7).
    d_in = 8'h11;
    step();
    save_req = 1'b1;
    load_req = 1'b1;
    step();
    save_req = 1'b0;
    load_req = 1'b0;
    for (int k = 0; k < SPAN; k++) step();
    check("R7 simul done", done, 1);
    step();
    check("R7 simul recall", busy, 1);
    finish_load(8'h11, 1'b0);

    // Power loss keeps the shadow (R9).
    do_save(8'hA5, 1'b0);
    step();
    pwr_ok = 1'b0;
    d_in = 8'hFF;
    save_req = 1'b1;
    step();
    check("R9 off clears q", q_out, 0);
    check("R9 off ignores save", busy, 0);
    save_req = 1'b0;
    load_req = 1'b1;
    step();
    check("R9 off ignores load", busy, 0);
    check("R9 off q still 0", q_out, 0);
    load_req = 1'b0;
    pwr_ok = 1'b1;
    step();
    check("R9 power back follow", q_out, 8'hFF);
    do_load(8'hA5, 1'b0);

    // Power loss in heating aborts the save (R10).
    d_in = 8'h3C;
    step();
    save_req = 1'b1;
    step();
    save_req = 1'b0;
    check("R10 save started", busy, 1);
    pwr_ok = 1'b0;
    step();
    check("R10 aborted busy", busy, 0);
    check("R10 aborted done", done, 0);
    pwr_ok = 1'b1;
    for (int k = 0; k < SPAN; k++) begin
      step();
      check("R10 no late done", done, 0);
    end
    do_load(8'hA5, 1'b0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule